// File: doc/BRIEF.md
# SMBus Clock-Line Idle and Stall Monitor

This block watches the clock line of a two-wire SMBus and turns its level history into two timing events. While the line is high, one timer measures an unbroken high period. When that period is long enough, the block raises a one-cycle bus-free pulse. If a START is waiting at that moment, it also raises a start-permit strobe, so the protocol engine can begin its transfer. While the line is low, a second timer measures how long the line stays down. When the stall limit is reached, the block sets a sticky timeout flag, and that flag drives an interrupt request. Software answers the interrupt by resetting the protocol engine and clearing the flag.

The two timers work in opposite polarity. The free-bus timer counts only while the line is high and reloads on any low level. The stall timer reloads while the line is high and counts only while it is low. Both timers count up from a reload value given on an input, and each fires when it rolls over the top of its width. The reload inputs and the counter widths therefore set the period together. With the block clock in mind, the free-bus period should be kept under 50 µs and the stall limit set near 25 ms.

Top module: `smb_idle_watch`

## Requirements
- R1: The raw clock-line input passes through a two-flop synchronizer. A level change is seen by the timers on the third rising clock edge after the input changes.
- R2: With `free_en`=1 and the synchronized line high, the free-bus timer counts up from `free_reload` once per cycle. `bus_free` is high for exactly one cycle after 2^FREE_W − `free_reload` counting edges, which is cycle N+2 after the raw input rises.
- R3: A synchronized low level reloads the free-bus timer, so only an unbroken high period can produce `bus_free`.
- R4: With `free_en`=0, the free-bus timer stays at its reload value and `bus_free` and `start_ok` stay 0.
- R5: `start_ok` pulses in the same cycle as `bus_free` only when `start_req` was 1 at the rollover edge; otherwise it stays 0.
- R6: With `low_en`=1 and `low_run`=1 and the synchronized line low, the stall timer counts up from `low_reload`. `scl_low_to` becomes 1 after 2^LOW_W − `low_reload` counting edges, which is cycle M+2 after the raw input falls.
- R7: A synchronized high level reloads the stall timer, so only an unbroken low period can set `scl_low_to`.
- R8: If either `low_en` or `low_run` is 0, the stall timer stays at reload and `scl_low_to` is never set.
- R9: `scl_low_to` stays set until `to_clear` is sampled high. A stall rollover on the same edge as `to_clear` takes priority and leaves the flag set.
- R10: `irq` always equals `scl_low_to`.
- R11: After reset, `bus_free`, `start_ok`, `scl_low_to` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw clock-line level, asynchronous |
| free_en | input | 1 | Enables the free-bus timer |
| low_en | input | 1 | Enables stall-timeout detection |
| low_run | input | 1 | Run control of the stall timer |
| start_req | input | 1 | A START is waiting for a free bus |
| free_reload | input | FREE_W | Start value of the free-bus timer |
| low_reload | input | LOW_W | Start value of the stall timer |
| to_clear | input | 1 | Clears the timeout flag |
| bus_free | output | 1 | One-cycle pulse on free-bus timer rollover |
| start_ok | output | 1 | One-cycle permit to issue the pending START |
| scl_low_to | output | 1 | Sticky clock-line-low timeout flag |
| irq | output | 1 | Interrupt request, equal to the timeout flag |

## Verification
The bench builds the block with FREE_W=4 and LOW_W=5. At these widths every reload value of both timers can be swept. Each sweep point compares the rollover cycle with 2^W − reload + 2, which covers the whole range from a one-cycle period up to the full counter span. The short periods also make it quick to reach interrupted high and low phases, set-versus-clear collisions and the disabled states.

// File: rtl/smbw_pkg.sv
// Package: shared types for the clock-line monitor.
// Assumes: nothing beyond the language.
package smbw_pkg;

    // Operation applied to an up-timer in the current cycle.
    typedef enum logic [1:0] {
        TM_HOLD  = 2'd0,
        TM_LOAD  = 2'd1,
        TM_COUNT = 2'd2
    } tmr_op_e;

endpackage

// File: rtl/smbw_sync.sv
// Module: smbw_sync
// A chain of STAGES flops that brings an asynchronous level into the clk domain.
// Assumes: STAGES >= 2; the idle level of the line is high, so reset loads ones.
module smbw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/smbw_uptimer.sv
// Module: smbw_uptimer
// An up-counter of width W. The op input tells it to hold, load the reload value,
// or count. When counting at the all-ones value it wraps to reload and asserts ovf
// in that cycle.
// Assumes: reload may change at any time; it is used only on load or wrap.
module smbw_uptimer
    import smbw_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tmr_op_e      op,
    input  logic [W-1:0] reload,
    output logic         ovf
);

    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt;

    // Rollover is flagged combinationally in the counting cycle that wraps.
    assign ovf = (op == TM_COUNT) && (cnt == TOP);

    // Apply the requested operation to the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case (op)
                TM_LOAD:  cnt <= reload;
                TM_COUNT: cnt <= (cnt == TOP) ? reload : cnt + 1'b1;
                default:  cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/smb_idle_watch.sv
// Module: smb_idle_watch (top)
// Watches the SMBus clock line. A free-bus timer runs while the line is high and
// produces a bus-free pulse, plus a start permit if a START is pending. A stall
// timer runs while the line is low and sets a sticky timeout flag that drives irq.
// Assumes: scl_in is asynchronous; the control inputs are synchronous to clk.
module smb_idle_watch
    import smbw_pkg::*;
#(
    parameter int FREE_W      = 12,
    parameter int LOW_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              free_en,
    input  logic              low_en,
    input  logic              low_run,
    input  logic              start_req,
    input  logic [FREE_W-1:0] free_reload,
    input  logic [LOW_W-1:0]  low_reload,
    input  logic              to_clear,
    output logic              bus_free,
    output logic              start_ok,
    output logic              scl_low_to,
    output logic              irq
);

    logic    scl_s;
    logic    free_ovf;
    logic    low_ovf;
    tmr_op_e free_op;
    tmr_op_e low_op;
    logic    low_armed;

    smbw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (scl_in),
        .q_sync  (scl_s)
    );

    // Free-bus timer: counts on high, reloads on low or when disabled.
    always_comb begin
        free_op = (free_en && scl_s) ? TM_COUNT : TM_LOAD;
    end

    // Stall timer: counts on low when armed, otherwise held at reload.
    always_comb begin
        low_armed = low_en && low_run;
        low_op    = (low_armed && !scl_s) ? TM_COUNT : TM_LOAD;
    end

    smbw_uptimer #(.W(FREE_W)) u_free_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (free_op),
        .reload (free_reload),
        .ovf    (free_ovf)
    );

    smbw_uptimer #(.W(LOW_W)) u_low_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (low_op),
        .reload (low_reload),
        .ovf    (low_ovf)
    );

    // Register the bus-free pulse and the start permit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_free <= 1'b0;
            start_ok <= 1'b0;
        end else begin
            bus_free <= free_ovf;
            start_ok <= free_ovf && start_req;
        end
    end

    // Sticky timeout flag; a new rollover wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        scl_low_to <= 1'b0;
        else if (low_ovf)  scl_low_to <= 1'b1;
        else if (to_clear) scl_low_to <= 1'b0;
    end

    assign irq = scl_low_to;

endmodule

// File: rtl/smbw_checker.sv
// Module: smbw_checker
// Temporal checks on the monitor, bound into every smb_idle_watch instance.
// Assumes: the synchronized line level is reachable as scl_s in the top module.
module smbw_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic free_en,
    input logic low_en,
    input logic low_run,
    input logic start_req,
    input logic to_clear,
    input logic bus_free,
    input logic start_ok,
    input logic scl_low_to
);

    a_r2_free_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
        bus_free |-> $past(scl_s));

    a_r4_free_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        bus_free |-> $past(free_en));

    a_r5_permit_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |-> (bus_free && $past(start_req)));

    a_r8_set_needs_armed_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_low_to) |-> $past(!scl_s && low_en && low_run));

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_low_to && !to_clear) |=> scl_low_to);

    a_r9_clear_when_high: assert property (@(posedge clk) disable iff (!rst_n)
        (to_clear && scl_s) |=> !scl_low_to);

endmodule

bind smb_idle_watch smbw_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .free_en    (free_en),
    .low_en     (low_en),
    .low_run    (low_run),
    .start_req  (start_req),
    .to_clear   (to_clear),
    .bus_free   (bus_free),
    .start_ok   (start_ok),
    .scl_low_to (scl_low_to)
);

// File: tb/tb_smb_idle_watch.sv
`timescale 1ns/1ps
// Bench: sweeps every reload value of both timers at small widths.
module tb_smb_idle_watch;

    localparam int FW = 4;
    localparam int LW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl_in = 1'b1;
    logic          free_en = 1'b0;
    logic          low_en = 1'b0;
    logic          low_run = 1'b0;
    logic          start_req = 1'b0;
    logic [FW-1:0] free_reload = '0;
    logic [LW-1:0] low_reload = '0;
    logic          to_clear = 1'b0;
    logic          bus_free, start_ok, scl_low_to, irq;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    smb_idle_watch #(.FREE_W(FW), .LOW_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .free_en(free_en),
        .low_en(low_en), .low_run(low_run), .start_req(start_req),
        .free_reload(free_reload), .low_reload(low_reload), .to_clear(to_clear),
        .bus_free(bus_free), .start_ok(start_ok), .scl_low_to(scl_low_to), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int first;
        int so;
        int hits;
        int irq_bad;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: outputs idle after reset
        chk(!bus_free && !start_ok && !scl_low_to && !irq, "R11",
            {bus_free, start_ok, scl_low_to, irq}, 0);

        // R1 R2 R5: free-bus rollover cycle for every reload value
        for (int r = 0; r < (1 << FW); r++) begin
            @(negedge clk);
            scl_in = 1'b0; free_en = 1'b1; free_reload = FW'(r); start_req = r[0];
            repeat (4) @(negedge clk);
            scl_in = 1'b1;
            first = 0; so = 0;
            for (int i = 1; i <= (1 << FW) - r + 2; i++) begin
                @(negedge clk);
                if (bus_free && first == 0) begin first = i; so = start_ok; end
            end
            chk(first == (1 << FW) - r + 2, "R1 R2", first, (1 << FW) - r + 2);
            chk(so == int'(start_req), "R5", so, int'(start_req));
        end

        // R3: broken high period never reaches rollover (reload 0, 16 needed)
        @(negedge clk);
        scl_in = 1'b0; free_reload = '0; start_req = 1'b1;
        repeat (4) @(negedge clk);
        hits = 0;
        scl_in = 1'b1;
        repeat (12) begin @(negedge clk); hits += int'(bus_free); end
        scl_in = 1'b0;
        repeat (3) begin @(negedge clk); hits += int'(bus_free); end
        scl_in = 1'b1;
        repeat (12) begin @(negedge clk); hits += int'(bus_free); end
        chk(hits == 0, "R3", hits, 0);

        // R4: disabled free-bus timer with the line high
        free_en = 1'b0; hits = 0;
        repeat (40) begin @(negedge clk); hits += int'(bus_free) + int'(start_ok); end
        chk(hits == 0, "R4", hits, 0);
        start_req = 1'b0;

        // R6 R9 R10: stall rollover cycle for every reload value
        low_en = 1'b1; low_run = 1'b1;
        for (int r = 0; r < (1 << LW); r++) begin
            @(negedge clk);
            scl_in = 1'b1; low_reload = LW'(r); to_clear = 1'b1;
            repeat (4) @(negedge clk);
            to_clear = 1'b0;
            chk(scl_low_to == 1'b0, "R9", int'(scl_low_to), 0);
            scl_in = 1'b0;
            first = 0; irq_bad = 0;
            for (int i = 1; i <= (1 << LW) - r + 2; i++) begin
                @(negedge clk);
                if (irq != scl_low_to) irq_bad++;
                if (scl_low_to && first == 0) first = i;
            end
            chk(first == (1 << LW) - r + 2, "R6", first, (1 << LW) - r + 2);
            chk(irq_bad == 0, "R10", irq_bad, 0);
        end

        // R9: flag holds with the line high and no clear
        @(negedge clk);
        scl_in = 1'b1;
        repeat (10) @(negedge clk);
        chk(scl_low_to == 1'b1, "R9", int'(scl_low_to), 1);

        // R9: rollover wins over a clear held on the same edge (reload 20, 12 edges)
        to_clear = 1'b1; low_reload = LW'(20);
        repeat (4) @(negedge clk);
        scl_in = 1'b0;
        for (int i = 1; i <= 15; i++) begin
            @(negedge clk);
            if (i == 13) chk(scl_low_to == 1'b0, "R9", int'(scl_low_to), 0);
            if (i == 14) chk(scl_low_to == 1'b1, "R9", int'(scl_low_to), 1);
            if (i == 15) chk(scl_low_to == 1'b0, "R9", int'(scl_low_to), 0);
        end
        scl_in = 1'b1;
        repeat (4) @(negedge clk);
        to_clear = 1'b0;

        // R7: broken low period never reaches rollover (reload 0, 32 needed)
        low_reload = '0; hits = 0;
        scl_in = 1'b0;
        repeat (25) begin @(negedge clk); hits += int'(scl_low_to); end
        scl_in = 1'b1;
        repeat (3) begin @(negedge clk); hits += int'(scl_low_to); end
        scl_in = 1'b0;
        repeat (25) begin @(negedge clk); hits += int'(scl_low_to); end
        chk(hits == 0, "R7", hits, 0);

        // R8: stall timer needs both arming bits
        scl_in = 1'b1;
        repeat (4) @(negedge clk);
        low_run = 1'b0; scl_in = 1'b0; hits = 0;
        repeat (40) begin @(negedge clk); hits += int'(scl_low_to); end
        chk(hits == 0, "R8", hits, 0);
        low_run = 1'b1; low_en = 1'b0; hits = 0;
        repeat (40) begin @(negedge clk); hits += int'(scl_low_to) + int'(irq); end
        chk(hits == 0, "R8", hits, 0);

        summary();
        $finish;
    end

endmodule